// File: doc/BRIEF.md
# Branch Event Counter Bank

This block counts branch-prediction events. Each cycle it receives a vector of event strobes, one bit per event, and keeps one wide counter per event. The events have fixed identifiers: 0 every prediction issued, 1 predicted taken, 2 any mispredict, 3 conditional predicted, 4 conditional mispredict, 5 indirect predicted, 6 indirect mispredict, 7 call, 8 return, 9 return mispredict, 10 return-stack push while full, 11 return-stack pop while empty, 12 fetch-queue full, 13 fetch-queue empty, 14 fetch dequeue while the queue was empty, 15 target-buffer miss, 16 fast target-buffer hit, 17 direction-table allocation, 18 confident loop prediction, 19 corrector override.

Software-facing logic reads a counter through a registered read port whose address is the event identifier. The same strobes are also placed on a wide system event bus at an offset of one, because slot zero of that bus is reserved to mean "no event". The remap is pure wiring: one bus strobe per event strobe, in the same cycle.

A parameter selects the counter overflow policy: wrap-around (the default) or saturation at all ones.

Top module: `bec_counter_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every counter and the read data register to zero, and strobes present during reset are not counted.
- R2: In each cycle that bit i of `evt_strb` is high and `rst` is low, counter i increases by exactly one. The other counters are not affected.
- R3: When `csr_re` is high at a clock edge, `csr_rdata` shows after that edge the value counter `csr_addr` held before that edge. A strobe in the same cycle is not included, and it shows up on the next read.
- R4: A read with `csr_addr` of NUM_EVT (20) or above returns zero.
- R5: While `csr_re` is low, `csr_rdata` keeps its last value, even when counters change.
- R6: With SATURATE = 0 (the default), a counter wraps modulo 2^CNT_W.
- R7: With SATURATE = 1, a counter that reaches all ones stays there.
- R8: In the same cycle, `evt_bus` bit i+1 equals `evt_strb` bit i for every event i. Bit 0 and every bit above NUM_EVT are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_strb | input | NUM_EVT (20) | Per-cycle event strobes, bit index = event id |
| csr_re | input | 1 | Read enable |
| csr_addr | input | ADDR_W (5) | Event id to read |
| csr_rdata | output | CNT_W (64) | Registered counter value |
| evt_bus | output | BUS_W (256) | System event bus, slot 0 reserved |

## Verification
The sharpest overlap is a read and an increment of the same counter in one cycle. The bench raises the strobe and the read enable on the same falling edge. It expects the read to return the count from before that edge, and a second read to return one more. A second overlap is reset against active strobes. All strobes are held high through reset, and the counters must still read zero afterwards. Wrap and saturation are driven past the top of a 4-bit counter on small extra instances.

// File: rtl/bec_pkg.sv
package bec_pkg;

   localparam int unsigned BEC_NUM_EVT  = 20;
   localparam int unsigned BEC_CNT_W    = 64;
   localparam int unsigned BEC_BUS_W    = 256;
   localparam int unsigned BEC_ADDR_W   = 5;
   localparam int unsigned BEC_BUS_BASE = 1;

   typedef enum logic [4:0] {
      EV_PRED_ALL      = 5'd0,
      EV_PRED_TAKEN    = 5'd1,
      EV_MISPRED       = 5'd2,
      EV_COND          = 5'd3,
      EV_COND_MISPRED  = 5'd4,
      EV_INDIR         = 5'd5,
      EV_INDIR_MISPRED = 5'd6,
      EV_CALL          = 5'd7,
      EV_RETURN        = 5'd8,
      EV_RET_MISPRED   = 5'd9,
      EV_RSTACK_OVF    = 5'd10,
      EV_RSTACK_UNF    = 5'd11,
      EV_QUEUE_FULL    = 5'd12,
      EV_QUEUE_EMPTY   = 5'd13,
      EV_FETCH_STARVE  = 5'd14,
      EV_TGT_MISS      = 5'd15,
      EV_FAST_TGT_HIT  = 5'd16,
      EV_DIR_ALLOC     = 5'd17,
      EV_LOOP_CONF     = 5'd18,
      EV_CORR_OVERRIDE = 5'd19
   } bec_evt_e;

   function automatic int unsigned bec_bus_slot(input int unsigned evt_id);
      return evt_id + BEC_BUS_BASE;
   endfunction

endpackage

// File: rtl/bec_counter.sv
module bec_counter #(
   parameter int unsigned CNT_W    = 64,
   parameter bit          SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] FULL = '1;

   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_nxt = cnt;
            if (inc && (cnt != FULL)) begin
               cnt_nxt = cnt + ONE;
            end
         end
      end else begin : g_wrap
         always_comb begin
            cnt_nxt = cnt;
            if (inc) begin
               cnt_nxt = cnt + ONE;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_nxt;
      end
   end

endmodule

// File: rtl/bec_readout.sv
module bec_readout #(
   parameter int unsigned NUM_EVT = 20,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [NUM_EVT-1:0][CNT_W-1:0]   cnt_all,
   input  logic                            rd_en,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [CNT_W-1:0]                rd_data
);

   logic [CNT_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (rd_addr == ADDR_W'(k)) begin
            sel = cnt_all[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= sel;
      end
   end

endmodule

// File: rtl/bec_bus_remap.sv
module bec_bus_remap #(
   parameter int unsigned NUM_EVT = 20,
   parameter int unsigned BUS_W   = 256
) (
   input  logic [NUM_EVT-1:0] strb,
   output logic [BUS_W-1:0]   bus
);

   localparam int unsigned BASE = bec_pkg::BEC_BUS_BASE;

   genvar s;
   generate
      for (s = 0; s < BUS_W; s++) begin : g_slot
         if ((s >= BASE) && (s < NUM_EVT + BASE)) begin : g_live
            assign bus[s] = strb[s - BASE];
         end else begin : g_tie
            assign bus[s] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/bec_counter_bank.sv
module bec_counter_bank #(
   parameter int unsigned NUM_EVT  = bec_pkg::BEC_NUM_EVT,
   parameter int unsigned CNT_W    = bec_pkg::BEC_CNT_W,
   parameter int unsigned BUS_W    = bec_pkg::BEC_BUS_W,
   parameter int unsigned ADDR_W   = bec_pkg::BEC_ADDR_W,
   parameter bit          SATURATE = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_EVT-1:0] evt_strb,
   input  logic               csr_re,
   input  logic [ADDR_W-1:0]  csr_addr,
   output logic [CNT_W-1:0]   csr_rdata,
   output logic [BUS_W-1:0]   evt_bus
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;
   localparam int unsigned BUS_NEED  = NUM_EVT + bec_pkg::BEC_BUS_BASE;

   generate
      if (BUS_W < BUS_NEED) begin : g_bad_bus
         $error("bec_counter_bank: BUS_W too narrow for NUM_EVT plus reserved slot");
      end
      if (ADDR_SPAN < NUM_EVT) begin : g_bad_addr
         $error("bec_counter_bank: ADDR_W cannot address every event");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("bec_counter_bank: CNT_W must be at least 2");
      end
   endgenerate

   logic [NUM_EVT-1:0][CNT_W-1:0] cnt_all;

   genvar e;
   generate
      for (e = 0; e < NUM_EVT; e++) begin : g_evt
         bec_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) i_cnt (
            .clk (clk),
            .rst (rst),
            .inc (evt_strb[e]),
            .cnt (cnt_all[e])
         );
      end
   endgenerate

   bec_readout #(
      .NUM_EVT (NUM_EVT),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W)
   ) i_rd (
      .clk     (clk),
      .rst     (rst),
      .cnt_all (cnt_all),
      .rd_en   (csr_re),
      .rd_addr (csr_addr),
      .rd_data (csr_rdata)
   );

   bec_bus_remap #(
      .NUM_EVT (NUM_EVT),
      .BUS_W   (BUS_W)
   ) i_remap (
      .strb (evt_strb),
      .bus  (evt_bus)
   );

endmodule

// File: rtl/bec_checker.sv
module bec_checker #(
   parameter int unsigned NUM_EVT = 20,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned BUS_W   = 256,
   parameter int unsigned ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_EVT-1:0] evt_strb,
   input logic               csr_re,
   input logic [ADDR_W-1:0]  csr_addr,
   input logic [CNT_W-1:0]   csr_rdata,
   input logic [BUS_W-1:0]   evt_bus
);

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (csr_rdata == '0)); // R1

   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (rst)
      (csr_re && (csr_addr >= ADDR_W'(NUM_EVT))) |=> (csr_rdata == '0)); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !csr_re |=> $stable(csr_rdata)); // R5

   AST_SLOT_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (evt_bus[0] == 1'b0)); // R8

   AST_ONE_FOR_ONE: assert property (@(posedge clk) disable iff (rst)
      ($countones(evt_bus) == $countones(evt_strb))); // R8

endmodule

bind bec_counter_bank bec_checker #(
   .NUM_EVT (NUM_EVT),
   .CNT_W   (CNT_W),
   .BUS_W   (BUS_W),
   .ADDR_W  (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .evt_strb  (evt_strb),
   .csr_re    (csr_re),
   .csr_addr  (csr_addr),
   .csr_rdata (csr_rdata),
   .evt_bus   (evt_bus)
);

// File: tb/test_bec_counter_bank.sv
`timescale 1ns/1ps
module test_bec_counter_bank;

   localparam int NE = 20;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NE-1:0] strb = '0;
   logic [NE-1:0] sstrb = '0;
   logic          re = 1'b0;
   logic [4:0]    addr = '0;
   logic [63:0]   rdata;
   logic [255:0]  bus;
   logic [SW-1:0] rdata_w, rdata_s;
   logic [255:0]  bus_w, bus_s;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [63:0] exp_cnt [NE];

   always #2.5 clk = ~clk;

   bec_counter_bank i_bec_counter_bank (
      .clk(clk), .rst(rst), .evt_strb(strb), .csr_re(re), .csr_addr(addr),
      .csr_rdata(rdata), .evt_bus(bus));

   bec_counter_bank #(.CNT_W(SW), .SATURATE(1'b0)) i_bec_counter_bank_w (
      .clk(clk), .rst(rst), .evt_strb(sstrb), .csr_re(re), .csr_addr(addr),
      .csr_rdata(rdata_w), .evt_bus(bus_w));

   bec_counter_bank #(.CNT_W(SW), .SATURATE(1'b1)) i_bec_counter_bank_s (
      .clk(clk), .rst(rst), .evt_strb(sstrb), .csr_re(re), .csr_addr(addr),
      .csr_rdata(rdata_s), .evt_bus(bus_s));

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input int a);
      @(negedge clk);
      re   = 1'b1;
      addr = 5'(a);
      @(negedge clk);
      re = 1'b0;
      #1;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [63:0] held;
      for (int i = 0; i < NE; i++) exp_cnt[i] = '0;

      // R1: strobes held high through reset must not count
      strb = '1;
      sstrb = '1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      strb = '0;
      sstrb = '0;
      #1;
      check("R1 rdata after reset", 256'(rdata), 256'(0));
      for (int i = 0; i < NE; i++) begin
         do_read(i);
         check("R1 counter zero after reset", 256'(rdata), 256'(0));
      end

      // R2 + R8: pattern where event i fires every (i+1)th cycle
      for (int c = 0; c < 120; c++) begin
         logic [NE-1:0] pat;
         @(negedge clk);
         pat = '0;
         for (int i = 0; i < NE; i++) if ((c % (i + 1)) == 0) pat[i] = 1'b1;
         if ((c % 7) == 3) pat = ~pat;
         strb = pat;
         for (int i = 0; i < NE; i++) exp_cnt[i] += 64'(pat[i]);
         #1;
         if ((c % 10) == 0 || c < 5) check("R8 bus remap", bus, {236'b0, pat} << 1);
      end
      @(negedge clk);
      strb = '0;
      #1;
      check("R8 bus idle", bus, 256'(0));
      for (int i = 0; i < NE; i++) begin
         do_read(i);
         check("R2 per-event count", 256'(rdata), 256'(exp_cnt[i]));
      end

      // R4: every out-of-range address returns zero
      for (int a = NE; a < 32; a++) begin
         do_read(a);
         check("R4 out-of-range read", 256'(rdata), 256'(0));
      end

      // R5: read data holds while counters move and re is low
      do_read(5);
      held = rdata;
      check("R5 setup read", 256'(held), 256'(exp_cnt[5]));
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         strb = '1;
         for (int i = 0; i < NE; i++) exp_cnt[i] += 64'd1;
         addr = 5'(c);
         #1;
         check("R5 hold while idle", 256'(rdata), 256'(held));
      end
      @(negedge clk);
      strb = '0;

      // R3: read and increment of the same counter in one cycle
      @(negedge clk);
      strb = 20'(1) << 3;
      re   = 1'b1;
      addr = 5'd3;
      @(negedge clk);
      strb = '0;
      re   = 1'b0;
      #1;
      check("R3 same-cycle read sees old value", 256'(rdata), 256'(exp_cnt[3]));
      exp_cnt[3] += 64'd1;
      do_read(3);
      check("R3 next read sees increment", 256'(rdata), 256'(exp_cnt[3]));
      do_read(19);
      check("R3 last event read", 256'(rdata), 256'(exp_cnt[19]));

      // R6 / R7: push a 4-bit counter past its top
      @(negedge clk);
      sstrb = 20'(1);
      repeat (18) @(negedge clk);
      sstrb = '0;
      do_read(0);
      check("R6 wrap modulo 16", 256'(rdata_w), 256'(18 % 16));
      check("R7 saturate at all ones", 256'(rdata_s), 256'(15));
      do_read(1);
      check("R6 untouched event", 256'(rdata_w), 256'(0));

      // R1: reset in mid-run, with strobes active
      @(negedge clk);
      rst = 1'b1;
      strb = '1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      strb = '0;
      #1;
      check("R1 rdata after mid-run reset", 256'(rdata), 256'(0));
      do_read(0);
      check("R1 counter 0 cleared", 256'(rdata), 256'(0));
      do_read(19);
      check("R1 counter 19 cleared", 256'(rdata), 256'(0));

      done = 1'b1;
      finish_run();
   end

endmodule